// File: doc/BRIEF.md
# Write-once watchdog timer

This block is a watchdog for a system bus. It has a single write port that holds one control word. The first write after reset sets the configuration, and the configuration cannot change after that. The control word carries a reload count, a prescaler enable, a run enable and a two-bit code that chooses the expiry action. That first write also loads the down-counter. Every later write reloads the counter from the stored reload count and ignores its own data. Software keeps the system alive by writing to the register often enough.

The counter advances on a timer tick that runs at half the bus clock rate. When the prescaler is enabled, the tick is divided again by a parameter whose default is 16384. When a tick arrives while the counter already holds zero, the watchdog expires. It then raises either an interrupt line or a reset-request line, chosen by the action code. The raised line stays high until the block is reset.

Top module: `wdt_once`

## Requirements
- R1: While and after reset, which is asynchronous and active low, `irq_o` and `rst_req_o` are low and the register is unconfigured again.
- R2: The first write captures the configuration. Bits 11:0 hold the reload count N, bit 12 the prescaler enable, bit 13 the run enable and bits 15:14 the action code. Later writes leave all of it unchanged.
- R3: Each write after the first reloads the counter from the stored N and restarts the tick phase, whatever data it carries.
- R4: With the prescaler disabled, the expiry output goes high exactly 2*(N+1) clock cycles after the edge of the last write, for every N from 0 to 4095.
- R5: With the prescaler enabled, the expiry output goes high exactly 2*(N+1)*PRE_DIV cycles after the edge of the last write.
- R6: Action code 2 drives expiry to `irq_o`. Codes 0, 1 and 3 drive it to `rst_req_o`. The two outputs are never high together.
- R7: If the first write has bit 13 clear, the configuration is locked and the watchdog never expires, even after later writes that have bit 13 set.
- R8: Once an expiry output is high, it stays high until reset, even through later writes.
- R9: A write on the same edge as a counter tick reloads the counter instead of decrementing it, so the full timeout starts again from that write.
- R10: After reset, a new first write can set a different configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write strobe for the control register, one cycle per write |
| wr_data | input | RELOAD_W+4 | Write data: reload count, prescaler enable, run enable, action code |
| irq_o | output | 1 | Expiry interrupt (action code 2), sticky |
| rst_req_o | output | 1 | Expiry reset request (other action codes), sticky |

## Verification
The main timing path is tried with every reload count from 0 to 63, and with the largest count, both with and without the prescaler. These runs tell an off-by-one in the count apart from an error in the half-rate divider or the prescaler. Retrigger writes are placed on tick edges and between ticks, and carry arbitrary data. These runs separate the reload-wins priority and the data-independence of retriggers from a decrement that slips through. Later writes that try to change the count, the action or the enable show that the first write is the only one that takes effect. The four action codes check how expiry is routed to the outputs.

// File: rtl/wdt_once_pkg.sv
package wdt_once_pkg;

  localparam int ACT_W = 2;

  typedef enum logic [ACT_W-1:0] {
    ACT_RESET_A = 2'd0,
    ACT_RESET_B = 2'd1,
    ACT_INTR    = 2'd2,
    ACT_RESET_C = 2'd3
  } wdt_act_e;

  function automatic logic act_is_intr(wdt_act_e a);
    return a == ACT_INTR;
  endfunction

endpackage

// File: rtl/wdt_cfg_latch.sv
module wdt_cfg_latch
  import wdt_once_pkg::*;
#(
  parameter int RELOAD_W = 12,
  localparam int DATA_W  = RELOAD_W + 2 + ACT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  output logic                locked_o,
  output logic [RELOAD_W-1:0] reload_o,
  output logic                pre_en_o,
  output logic                run_en_o,
  output wdt_act_e            act_o
);

  localparam int PRE_BIT = RELOAD_W;
  localparam int EN_BIT  = RELOAD_W + 1;
  localparam int ACT_LSB = RELOAD_W + 2;

  logic                locked_q, locked_d;
  logic [RELOAD_W-1:0] reload_q, reload_d;
  logic                pre_q, pre_d;
  logic                en_q, en_d;
  wdt_act_e            act_q, act_d;
  logic                take;

  assign take = wr_en && !locked_q;

  always_comb begin
    locked_d = locked_q;
    reload_d = reload_q;
    pre_d    = pre_q;
    en_d     = en_q;
    act_d    = act_q;
    if (take) begin
      locked_d = 1'b1;
      reload_d = wr_data[RELOAD_W-1:0];
      pre_d    = wr_data[PRE_BIT];
      en_d     = wr_data[EN_BIT];
      act_d    = wdt_act_e'(wr_data[ACT_LSB +: ACT_W]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      reload_q <= '0;
      pre_q    <= 1'b0;
      en_q     <= 1'b0;
      act_q    <= ACT_RESET_A;
    end else if (take) begin
      locked_q <= locked_d;
      reload_q <= reload_d;
      pre_q    <= pre_d;
      en_q     <= en_d;
      act_q    <= act_d;
    end
  end

  assign locked_o = locked_q;
  assign reload_o = reload_q;
  assign pre_en_o = pre_q;
  assign run_en_o = en_q;
  assign act_o    = act_q;

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> (locked_q && $stable(reload_q) && $stable(pre_q)
                  && $stable(en_q) && $stable(act_q)));

  // R2
  cfg_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !locked_q) |=> (locked_q && reload_q == $past(wr_data[RELOAD_W-1:0])));

endmodule

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter int PRE_DIV = 16384,
  localparam int PRE_W  = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic restart_i,
  input  logic pre_en_i,
  output logic tick_o
);

  logic half_q, half_d;
  logic base_tick;

  assign base_tick = run_i && half_q;

  always_comb begin
    half_d = half_q;
    if (restart_i)  half_d = 1'b0;
    else if (run_i) half_d = ~half_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                half_q <= 1'b0;
    else if (restart_i || run_i) half_q <= half_d;
  end

  generate
    if (PRE_DIV > 1) begin : g_prescale
      localparam logic [PRE_W-1:0] LAST = PRE_W'(PRE_DIV - 1);
      logic [PRE_W-1:0] pre_q, pre_d;
      logic             pre_ce;

      assign pre_ce = restart_i || (base_tick && pre_en_i);

      always_comb begin
        pre_d = pre_q;
        if (restart_i)         pre_d = '0;
        else if (pre_q == LAST) pre_d = '0;
        else                    pre_d = pre_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pre_q <= '0;
        else if (pre_ce) pre_q <= pre_d;
      end

      assign tick_o = base_tick && (!pre_en_i || pre_q == LAST);
    end else begin : g_no_prescale
      logic unused_pre;
      assign unused_pre = pre_en_i;
      assign tick_o     = base_tick;
    end
  endgenerate

  // R4
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

  // R3
  tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !tick_o);

endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             irq_sel_i,
  output logic             irq_o,
  output logic             rst_req_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             irq_q, irq_d;
  logic             rreq_q, rreq_d;
  logic             step, fire, cnt_ce;

  assign step   = run_i && tick_i && !load_i;
  assign fire   = step && (cnt_q == '0);
  assign cnt_ce = load_i || (step && !fire);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)     cnt_d = load_val_i;
    else if (step)  cnt_d = cnt_q - 1'b1;
  end

  always_comb begin
    irq_d  = irq_q  || (fire && irq_sel_i);
    rreq_d = rreq_q || (fire && !irq_sel_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      rreq_q <= 1'b0;
    end else if (fire) begin
      irq_q  <= irq_d;
      rreq_q <= rreq_d;
    end
  end

  assign irq_o     = irq_q;
  assign rst_req_o = rreq_q;

  // R9
  reload_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_q == $past(load_val_i));

  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> irq_q);

  // R8
  rreq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rreq_q |=> rreq_q);

  // R4
  no_count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> cnt_q <= $past(cnt_q));

endmodule

// File: rtl/wdt_once.sv
module wdt_once
  import wdt_once_pkg::*;
#(
  parameter int RELOAD_W = 12,
  parameter int PRE_DIV  = 16384
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [RELOAD_W+3:0]   wr_data,
  output logic                  irq_o,
  output logic                  rst_req_o
);

  logic                locked;
  logic [RELOAD_W-1:0] reload;
  logic                pre_en;
  logic                run_en;
  wdt_act_e            act;
  logic                running;
  logic                tick;
  logic [RELOAD_W-1:0] load_val;

  wdt_cfg_latch #(.RELOAD_W(RELOAD_W)) i_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .locked_o (locked),
    .reload_o (reload),
    .pre_en_o (pre_en),
    .run_en_o (run_en),
    .act_o    (act)
  );

  assign running  = locked && run_en;
  assign load_val = locked ? reload : wr_data[RELOAD_W-1:0];

  wdt_tick_gen #(.PRE_DIV(PRE_DIV)) i_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (running),
    .restart_i (wr_en),
    .pre_en_i  (pre_en),
    .tick_o    (tick)
  );

  wdt_down_counter #(.CNT_W(RELOAD_W)) i_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (wr_en),
    .load_val_i (load_val),
    .tick_i     (tick),
    .run_i      (running),
    .irq_sel_i  (act_is_intr(act)),
    .irq_o      (irq_o),
    .rst_req_o  (rst_req_o)
  );

  // R6
  one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_o && rst_req_o));

  // R7
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!irq_o && !rst_req_o));

  // R6
  irq_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> act == ACT_INTR);

endmodule

// File: tb/test_wdt_once.sv
module test_wdt_once;

  localparam int CLK_PERIOD = 10;
  localparam int RW         = 12;
  localparam int PDIV       = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [RW+3:0] wr_data;
  logic          irq_o, rst_req_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_once #(.RELOAD_W(RW), .PRE_DIV(PDIV)) i_wdt_once (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  function automatic logic [RW+3:0] mk(int n, bit pre, bit en, int act);
    return {act[1:0], en, pre, n[RW-1:0]};
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    wr_en = 1'b0; wr_data = '0; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(logic [RW+3:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1; wr_en = 1'b0; wr_data = '0;
  endtask

  // counts edges after the last write until an expiry output is seen
  task automatic wait_exp(int maxc, output int first, output bit was_irq);
    first = -1; was_irq = 1'b0;
    for (int c = 1; c <= maxc; c++) begin
      @(posedge clk); #1;
      if (irq_o || rst_req_o) begin
        first = c; was_irq = irq_o; break;
      end
    end
  endtask

  initial begin
    int f; bit wi; int t;
    do_reset();
    // R1
    #1;
    check(!irq_o && !rst_req_o, "R1 reset outputs", {irq_o, rst_req_o}, 0);

    // R4 sweep without prescaler
    for (int n = 0; n < 64; n++) begin
      do_reset(); wr(mk(n, 0, 1, 2)); t = 2*(n+1);
      wait_exp(t+4, f, wi);
      check(f == t, "R4 timeout", f, t);
    end
    do_reset(); wr(mk(4095, 0, 1, 2)); t = 2*4096;
    wait_exp(t+4, f, wi);
    check(f == t, "R4 max reload", f, t);

    // R5 sweep with prescaler
    for (int n = 0; n < 16; n++) begin
      do_reset(); wr(mk(n, 1, 1, 0)); t = 2*(n+1)*PDIV;
      wait_exp(t+4, f, wi);
      check(f == t, "R5 prescaled timeout", f, t);
    end
    do_reset(); wr(mk(4095, 1, 1, 0)); t = 2*4096*PDIV;
    wait_exp(t+4, f, wi);
    check(f == t, "R5 max prescaled", f, t);

    // R6 action routing
    for (int a = 0; a < 4; a++) begin
      do_reset(); wr(mk(1, 0, 1, a));
      wait_exp(8, f, wi);
      check(f == 4, "R6 timing", f, 4);
      check(wi == (a == 2), "R6 irq route", wi, a == 2);
      check(irq_o != rst_req_o, "R6 single output", {irq_o, rst_req_o}, (a == 2) ? 2 : 1);
    end

    // R2 later write cannot change reload, prescaler or action
    do_reset(); wr(mk(3, 0, 1, 2)); wr('1); t = 8;
    wait_exp(t+4, f, wi);
    check(f == t, "R2 reload kept", f, t);
    check(wi == 1'b1, "R2 action kept", wi, 1);

    // R3 retrigger with arbitrary data restarts timeout
    do_reset(); wr(mk(5, 0, 1, 1));
    repeat (5) @(posedge clk);
    wr(16'hABCD); t = 12;
    wait_exp(t+4, f, wi);
    check(f == t, "R3 retrigger data ignored", f, t);

    // R3 periodic retrigger keeps the watchdog quiet
    do_reset(); wr(mk(2, 0, 1, 2));
    for (int k = 0; k < 10; k++) begin
      repeat (3) @(posedge clk); wr(16'h0000);
    end
    check(!irq_o && !rst_req_o, "R3 kept alive", {irq_o, rst_req_o}, 0);

    // R9 retrigger on a tick edge (edge E+4 consumes tick 2)
    do_reset(); wr(mk(3, 0, 1, 2));
    repeat (3) @(posedge clk);
    wr(16'h1234); t = 8;
    wait_exp(t+4, f, wi);
    check(f == t, "R9 reload beats tick", f, t);

    // R7 disabled configuration locks and never expires
    do_reset(); wr(mk(0, 0, 0, 2)); wr(mk(0, 0, 1, 2));
    wait_exp(200, f, wi);
    check(f == -1, "R7 stays idle", f, -1);

    // R8 sticky after expiry, through writes
    do_reset(); wr(mk(0, 0, 1, 3));
    wait_exp(6, f, wi);
    check(f == 2, "R8 expiry", f, 2);
    wr(16'h0); repeat (20) @(posedge clk); #1;
    check(rst_req_o && !irq_o, "R8 sticky", {irq_o, rst_req_o}, 1);

    // R10 reset allows new configuration
    do_reset(); #1;
    check(!rst_req_o, "R1 reset clears flag", rst_req_o, 0);
    wr(mk(2, 0, 1, 2)); t = 6;
    wait_exp(t+4, f, wi);
    check(f == t && wi, "R10 reconfigure", f, t);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule